// File: doc/BRIEF.md
# Standby and Wake Controller

This block parks a small processor core in one of two low-power states and brings it back when a qualified key is pressed. In the light state the core is stalled and its clock source keeps running. In the deep state the oscillator enable is also dropped. The core issues a standby request that carries a 4-bit operand. The controller accepts it only when the core's status flag is already clear. A bad operand, or a request made while the flag is set, causes a one-cycle reset pulse.

Each key input has its own wake-enable bit. A key whose enable bit is low is an ordinary input and never wakes the core. The deep state is left through a settling wait of `WAIT_CYCLES` cycles with the oscillator enable high and the core still stalled. At the end of that wait the wake condition is checked again. If no enabled key is still held, the controller drops the oscillator enable and returns to the deep state.

Top module: `standby_wake_ctrl`

## Requirements
- R1: While reset is held and right after it, `osc_en` is 1, `core_stall` is 0 and `sys_rst` is 0.
- R2: A request with operand 4'b0001 (light standby) and `status_flag` low sets `core_stall` to 1 after the next edge, and `osc_en` stays 1.
- R3: A request with operand 4'b0010 (deep standby) and `status_flag` low sets `osc_en` to 0 and `core_stall` to 1 after the next edge. `osc_en` is never 0 unless `core_stall` is 1.
- R4: A request made while `status_flag` is 1 raises `sys_rst` for exactly one cycle and enters no standby state.
- R5: A request with any operand other than 4'b0001 or 4'b0010 raises `sys_rst` for exactly one cycle, after which the controller is running (`core_stall` 0, `osc_en` 1).
- R6: In light standby, an edge that sees a key high with its `wake_en` bit set clears `core_stall` for the following cycle, with no settling wait.
- R7: In deep standby, an edge that sees a qualified key sets `osc_en` to 1. `core_stall` stays 1 for exactly `WAIT_CYCLES` cycles from that edge.
- R8: At the last edge of the settling wait, if a qualified key is still held the core resumes (`core_stall` 0). Otherwise `osc_en` returns to 0 and deep standby holds until the next qualified key.
- R9: A key whose `wake_en` bit is 0 never releases either standby state.
- R10: `req_valid` is ignored while the controller is in any standby or settling state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Standby request strobe from the core |
| req_mode | input | 4 | Standby operand: 4'b0001 light, 4'b0010 deep |
| status_flag | input | 1 | Core status flag; must be 0 for a request to be accepted |
| wake_key | input | NUM_KEYS | Key input levels |
| wake_en | input | NUM_KEYS | Per-key wake enable |
| osc_en | output | 1 | Oscillator enable |
| core_stall | output | 1 | Holds the core stopped |
| sys_rst | output | 1 | One-cycle system reset pulse |

## Verification
The assertions assume that `req_valid`, `wake_key` and `wake_en` are synchronous to `clk` and stable around each edge. They also assume the clock keeps running while `osc_en` is low, so that the deep state can see a key and leave. The stimulus changes inputs just after a rising edge and keeps the clock free-running throughout. The settling-wait checks use a short wait, and keys are held or released on the cycles around the final count.

// File: rtl/standby_wake_ctrl.sv
module standby_wake_ctrl #(
  parameter int NUM_KEYS    = 4,
  parameter int WAIT_CYCLES = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [3:0]          req_mode,
  input  logic                status_flag,
  input  logic [NUM_KEYS-1:0] wake_key,
  input  logic [NUM_KEYS-1:0] wake_en,
  output logic                osc_en,
  output logic                core_stall,
  output logic                sys_rst
);

  localparam int CNT_W = $clog2(WAIT_CYCLES + 1);
  localparam logic [3:0] OP_LIGHT = 4'b0001;
  localparam logic [3:0] OP_DEEP  = 4'b0010;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYCLES - 1);

  typedef enum logic [2:0] {
    S_RUN, S_LIGHT, S_DEEP, S_SETTLE, S_RSTP
  } state_t;

  state_t           st;
  logic [CNT_W-1:0] cnt;
  logic             wake;
  logic             op_ok;

  assign wake  = |(wake_key & wake_en);
  assign op_ok = (req_mode == OP_LIGHT) || (req_mode == OP_DEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_RUN;
      cnt <= '0;
    end else begin
      case (st)
        S_RUN:
          if (req_valid) begin
            if (status_flag || !op_ok) st <= S_RSTP;
            else if (req_mode == OP_LIGHT) st <= S_LIGHT;
            else st <= S_DEEP;
          end
        S_LIGHT:
          if (wake) st <= S_RUN;
        S_DEEP:
          if (wake) begin
            st  <= S_SETTLE;
            cnt <= '0;
          end
        S_SETTLE:
          if (cnt == LAST) st <= wake ? S_RUN : S_DEEP;
          else cnt <= cnt + 1'b1;
        default:
          st <= S_RUN;
      endcase
    end
  end

  assign osc_en     = (st != S_DEEP);
  assign core_stall = (st == S_LIGHT) || (st == S_DEEP) || (st == S_SETTLE);
  assign sys_rst    = (st == S_RSTP);

endmodule

// File: rtl/standby_wake_chk.sv
module standby_wake_chk #(
  parameter int NUM_KEYS    = 4,
  parameter int WAIT_CYCLES = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [NUM_KEYS-1:0] wake_key,
  input logic [NUM_KEYS-1:0] wake_en,
  input logic                osc_en,
  input logic                core_stall,
  input logic                sys_rst
);

  localparam int CW = $clog2(WAIT_CYCLES + 2);

  logic          osc_q;
  logic          in_settle;
  logic [CW-1:0] scnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_q     <= 1'b1;
      in_settle <= 1'b0;
      scnt      <= '0;
    end else begin
      osc_q <= osc_en;
      if (osc_en && !osc_q) begin
        in_settle <= 1'b1;
        scnt      <= CW'(1);
      end else if (in_settle) begin
        if (!(osc_en && core_stall)) in_settle <= 1'b0;
        else scnt <= scnt + 1'b1;
      end
    end
  end

  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> !sys_rst); // R5

  AST_RST_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> $past(req_valid && !core_stall)); // R4

  AST_OSC_OFF_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> core_stall); // R3

  AST_EXIT_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_stall) |-> $past(|(wake_key & wake_en))); // R9

  AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_settle && scnt < CW'(WAIT_CYCLES)) |-> (osc_en && core_stall)); // R7

  AST_SETTLE_END: assert property (@(posedge clk) disable iff (!rst_n)
    (in_settle && scnt == CW'(WAIT_CYCLES)) |-> !(osc_en && core_stall)); // R8

endmodule

bind standby_wake_ctrl standby_wake_chk #(
  .NUM_KEYS(NUM_KEYS),
  .WAIT_CYCLES(WAIT_CYCLES)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .req_valid(req_valid),
  .wake_key(wake_key),
  .wake_en(wake_en),
  .osc_en(osc_en),
  .core_stall(core_stall),
  .sys_rst(sys_rst)
);

// File: tb/test_standby_wake_ctrl.sv
`timescale 1ns/1ps
module test_standby_wake_ctrl;

  localparam int NK = 4;
  localparam int W  = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [3:0]    req_mode = 4'b0;
  logic          status_flag = 1'b0;
  logic [NK-1:0] wake_key = '0;
  logic [NK-1:0] wake_en = '0;
  logic          osc_en, core_stall, sys_rst;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  typedef struct {
    int    due;
    logic  osc;
    logic  stall;
    logic  rst;
    string tag;
  } exp_t;

  exp_t q[$];

  standby_wake_ctrl #(.NUM_KEYS(NK), .WAIT_CYCLES(W)) i_standby_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .status_flag(status_flag), .wake_key(wake_key), .wake_en(wake_en),
    .osc_en(osc_en), .core_stall(core_stall), .sys_rst(sys_rst)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic compare(input exp_t e);
    checks++;
    if (osc_en !== e.osc || core_stall !== e.stall || sys_rst !== e.rst) begin
      fails++;
      $display("FAIL %s: got osc=%b stall=%b rst=%b expected osc=%b stall=%b rst=%b",
               e.tag, osc_en, core_stall, sys_rst, e.osc, e.stall, e.rst);
    end
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      compare(e);
    end
  end

  task automatic step(input logic rv, input logic [3:0] md, input logic fl,
                      input logic [NK-1:0] k, input logic [NK-1:0] en,
                      input logic eo, input logic es, input logic er,
                      input string tag);
    exp_t e;
    @(posedge clk); #1;
    req_valid = rv; req_mode = md; status_flag = fl;
    wake_key = k; wake_en = en;
    e.due = cyc + 1; e.osc = eo; e.stall = es; e.rst = er; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    begin
      exp_t e;
      e.due = 0; e.osc = 1; e.stall = 0; e.rst = 0; e.tag = "R1 in reset";
      compare(e);
    end
    rst_n = 1'b1;
    step(0, 4'h0, 0, '0, '0, 1, 0, 0, "R1 after reset");
    step(0, 4'h0, 0, '0, '0, 1, 0, 0, "R1 idle");

    // light standby
    step(1, 4'b0001, 0, '0, '0, 1, 1, 0, "R2 light entry");
    step(0, 4'h0, 0, 4'b0100, 4'b0011, 1, 1, 0, "R9 disabled key in light");
    step(1, 4'b0111, 0, '0, '0, 1, 1, 0, "R10 request ignored in light");
    step(0, 4'h0, 0, 4'b0010, 4'b0010, 1, 0, 0, "R6 light release");
    step(0, 4'h0, 0, '0, '0, 1, 0, 0, "R6 running");

    // deep standby, key held through wait
    step(1, 4'b0010, 0, '0, '0, 0, 1, 0, "R3 deep entry");
    step(0, 4'h0, 0, 4'b1000, 4'b0111, 0, 1, 0, "R9 disabled key in deep");
    step(1, 4'b0001, 0, '0, '0, 0, 1, 0, "R10 request ignored in deep");
    step(0, 4'h0, 0, 4'b0001, 4'b0001, 1, 1, 0, "R7 oscillator restart");
    for (int i = 1; i < W; i++)
      step(0, 4'h0, 0, 4'b0001, 4'b0001, 1, 1, 0, "R7 settling");
    step(0, 4'h0, 0, 4'b0001, 4'b0001, 1, 0, 0, "R8 resume after wait");
    step(0, 4'h0, 0, '0, '0, 1, 0, 0, "R8 running");

    // deep standby, key released during wait
    step(1, 4'b0010, 0, '0, '0, 0, 1, 0, "R3 deep entry again");
    step(0, 4'h0, 0, 4'b0100, 4'b0100, 1, 1, 0, "R7 restart");
    for (int i = 1; i < W; i++)
      step(0, 4'h0, 0, '0, 4'b0100, 1, 1, 0, "R7 settling no key");
    step(0, 4'h0, 0, '0, 4'b0100, 0, 1, 0, "R8 fall back to deep");
    step(0, 4'h0, 0, '0, 4'b0100, 0, 1, 0, "R8 stays deep");
    step(0, 4'h0, 0, 4'b0100, 4'b0100, 1, 1, 0, "R7 second restart");
    for (int i = 1; i < W; i++)
      step(0, 4'h0, 0, 4'b0100, 4'b0100, 1, 1, 0, "R7 settling held");
    step(0, 4'h0, 0, 4'b0100, 4'b0100, 1, 0, 0, "R8 resume");

    // reset pulses
    step(1, 4'b0111, 0, '0, '0, 1, 0, 1, "R5 illegal operand pulse");
    step(0, 4'h0, 0, '0, '0, 1, 0, 0, "R5 pulse ends, running");
    step(1, 4'b0000, 0, '0, '0, 1, 0, 1, "R5 zero operand pulse");
    step(0, 4'h0, 0, '0, '0, 1, 0, 0, "R5 pulse single cycle");
    step(1, 4'b0001, 1, '0, '0, 1, 0, 1, "R4 flag set pulse");
    step(0, 4'h0, 0, '0, '0, 1, 0, 0, "R4 no standby entered");
    step(1, 4'b0010, 1, '0, '0, 1, 0, 1, "R4 deep with flag pulse");
    step(0, 4'h0, 0, '0, '0, 1, 0, 0, "R4 oscillator kept");

    repeat (3) @(posedge clk);
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

endmodule